// File: doc/BRIEF.md
# Bernoulli Dropout Mask Generator

This block supplies filter-wise dropout masks to a layer-serial neural network engine that runs Monte Carlo dropout inference. Several single-bit maximal-length shift-register generators run side by side. For each mask bit, the outputs of the first k generators are ANDed, so a bit is one with probability 2^-k. A shift stage gathers PF such bits into one mask word, with one bit per filter handled in parallel. A small first-word-fall-through queue holds finished words until the compute pipeline takes them.

All generators share one step signal. Generation stops while a finished word waits for room in the queue. Because of this, the sequence of words that comes out depends only on the seeds and on the probability select. It does not depend on when the consumer pops. Successive Monte Carlo passes draw consecutive words, so the masks differ from pass to pass while a single shared sampler serves the whole engine.

Top module: `dropout_mask_gen`

## Requirements
- R1: While `rst_n` is low and on the first cycles after it rises, `empty_o` is 1. After every reset, generation restarts from the seeds.
- R2: Each generator is a 32-bit register s. On each step s becomes {s[30:0], s[31]^s[21]^s[1]^s[0]}. Its output bit is s[31] taken before the step.
- R3: Generator j loads slice j of `seed_i` (bits 32j+31..32j) during reset. A zero slice is replaced by the value j+1, so a generator state is never zero.
- R4: `prob_sel_i` values 1, 2 and 3 select k = 1, 2 and 3. The value 0 selects k = 1. Each mask bit is the AND of the output bits of generators 0..k-1 at the same step. `prob_sel_i` is changed only during reset.
- R5: PF consecutive mask bits form one word, with the earliest bit in bit 0. All generators step together, one step per cycle, only while a word is being collected. Handing a word to the queue takes one cycle with no step.
- R6: A finished word enters the queue only when the queue is not full. Otherwise generation stalls, and no bit is lost or repeated.
- R7: Whenever `empty_o` is 0, `mask_o` shows the oldest queued word. A cycle with `pop_i` high removes that word.
- R8: `pop_i` while `empty_o` is 1 is ignored: no word is dropped.
- R9: Words leave in the order they were built, so successive pops return consecutive PF-bit slices of the mask-bit stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset; seeds are loaded while it is low |
| seed_i | input | K_MAX*32 | one 32-bit seed per generator |
| prob_sel_i | input | $clog2(K_MAX+1) | number k of ANDed generator bits |
| pop_i | input | 1 | remove the word shown on `mask_o` |
| mask_o | output | PF | oldest queued mask word |
| empty_o | output | 1 | queue holds no word |

## Verification
The hardest case to reach is a stall: the queue is full and a finished word is held in the shift stage. In that state the generators must freeze without losing a bit. The stimulus reaches it by leaving the consumer idle for many word times and then popping the queue back to back. The popped words are compared with a bench model of the stream, which shows that nothing was skipped. Pops are also issued into an empty queue right after reset, with random gaps, under every probability code, and with an all-zero seed slice.

// File: rtl/mg_pkg.sv
package mg_pkg;
  localparam int GEN_W = 32;

  // one step of a generator: shift left, feed in the xor of the tap bits
  function automatic logic [GEN_W-1:0] gen_next(input logic [GEN_W-1:0] s);
    return {s[GEN_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  // a zero seed would lock the register; substitute index+1
  function automatic logic [GEN_W-1:0] seed_fix(input logic [GEN_W-1:0] s, input int idx);
    return (s == '0) ? GEN_W'(idx + 1) : s;
  endfunction

  // number of ANDed bits selected by the probability code
  function automatic int sel_to_k(input int code, input int kmax);
    int k;
    k = (code == 0) ? 1 : code;
    return (k > kmax) ? kmax : k;
  endfunction
endpackage

// File: rtl/mg_gen.sv
module mg_gen
  import mg_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GEN_W-1:0] seed_i,
  input  logic             step_i,
  output logic             bit_o
);
  logic [GEN_W-1:0] state;

  always_ff @(posedge clk) begin
    if (!rst_n)      state <= seed_fix(seed_i, IDX);
    else if (step_i) state <= gen_next(state);
  end

  assign bit_o = state[GEN_W-1];

  AST_STATE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0); // R3
endmodule

// File: rtl/mg_sipo.sv
module mg_sipo #(
  parameter int PF = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_i,
  input  logic          full_i,
  output logic          step_o,
  output logic          push_o,
  output logic [PF-1:0] word_o
);
  localparam int CW = $clog2(PF + 1);

  logic [CW-1:0] cnt;
  logic [PF-1:0] sr;
  logic          word_ready;

  assign word_ready = (cnt == CW'(PF));
  assign step_o     = !word_ready;
  assign push_o     = word_ready && !full_i;
  assign word_o     = sr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      sr  <= '0;
    end else if (step_o) begin
      cnt <= cnt + CW'(1);
      sr  <= {bit_i, sr[PF-1:1]};
    end else if (push_o) begin
      cnt <= '0;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (word_ready && full_i) |=> $stable(sr)); // R6
endmodule

// File: rtl/mg_fifo.sv
module mg_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [NW-1:0] count;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full_o  = (count == NW'(DEPTH));
  assign empty_o = (count == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
      count <= count + NW'(do_push) - NW'(do_pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !push_i); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && pop_i && !push_i) |=> empty_o); // R8
endmodule

// File: rtl/dropout_mask_gen.sv
module dropout_mask_gen
  import mg_pkg::*;
#(
  parameter int PF    = 8,
  parameter int K_MAX = 3,
  parameter int DEPTH = 4,
  localparam int SW   = $clog2(K_MAX + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [K_MAX*GEN_W-1:0] seed_i,
  input  logic [SW-1:0]          prob_sel_i,
  input  logic                   pop_i,
  output logic [PF-1:0]          mask_o,
  output logic                   empty_o
);
  logic [K_MAX-1:0] gen_bits;
  logic             step, push, full, mask_bit;
  logic [PF-1:0]    word;
  int               k_sel;

  for (genvar j = 0; j < K_MAX; j++) begin : g_gen
    mg_gen #(.IDX(j)) i_gen (
      .clk    (clk),
      .rst_n  (rst_n),
      .seed_i (seed_i[j*GEN_W +: GEN_W]),
      .step_i (step),
      .bit_o  (gen_bits[j])
    );
  end

  assign k_sel = sel_to_k(int'(prob_sel_i), K_MAX);

  always_comb begin
    mask_bit = 1'b1;
    for (int j = 0; j < K_MAX; j++)
      if (j < k_sel) mask_bit = mask_bit & gen_bits[j];
  end

  mg_sipo #(.PF(PF)) i_sipo (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_i  (mask_bit),
    .full_i (full),
    .step_o (step),
    .push_o (push),
    .word_o (word)
  );

  mg_fifo #(.W(PF), .DEPTH(DEPTH)) i_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push),
    .data_i  (word),
    .pop_i   (pop_i),
    .data_o  (mask_o),
    .full_o  (full),
    .empty_o (empty_o)
  );

  AST_EMPTY_AFTER_RESET: assert property (@(posedge clk)
    $rose(rst_n) |-> empty_o); // R1
  AST_NO_STEP_ON_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !step); // R5
endmodule

// File: tb/test_dropout_mask_gen.sv
module test_dropout_mask_gen;
  localparam int PF = 8, K = 3, DEPTH = 4, LW = 32;

  logic            clk = 1'b0, rst_n = 1'b0, pop_i = 1'b0;
  logic [1:0]      prob_i = 2'd1;
  logic [K*LW-1:0] seed_i = '0;
  logic [PF-1:0]   mask_o;
  logic            empty_o;

  always #10 clk = ~clk;

  dropout_mask_gen #(.PF(PF), .K_MAX(K), .DEPTH(DEPTH)) i_dropout_mask_gen (
    .clk(clk), .rst_n(rst_n), .seed_i(seed_i), .prob_sel_i(prob_i),
    .pop_i(pop_i), .mask_o(mask_o), .empty_o(empty_o));

  int checks = 0, errors = 0, k_cur = 1;
  bit done = 0;
  logic [LW-1:0] ms [K];

  function automatic logic [LW-1:0] m_next(input logic [LW-1:0] s);
    return (s << 1) | LW'(^(s & 32'h8020_0003));
  endfunction

  task automatic m_word(output logic [PF-1:0] w);
    for (int i = 0; i < PF; i++) begin
      logic b;
      b = 1'b1;
      for (int j = 0; j < K; j++) if (j < k_cur) b = b & ms[j][LW-1];
      w[i] = b;
      for (int j = 0; j < K; j++) ms[j] = m_next(ms[j]);
    end
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [K*LW-1:0] sd, input logic [1:0] p);
    @(negedge clk);
    rst_n = 1'b0; seed_i = sd; prob_i = p;
    repeat (3) @(negedge clk);
    for (int j = 0; j < K; j++)
      ms[j] = (sd[j*LW +: LW] == '0) ? LW'(j + 1) : sd[j*LW +: LW];
    k_cur = (p == 0) ? 1 : int'(p);
    rst_n = 1'b1;
  endtask

  task automatic pop_check(input string req, output logic [PF-1:0] got);
    logic [PF-1:0] exp;
    int n;
    n = 0;
    while (empty_o && n < 1000) begin @(negedge clk); n++; end
    m_word(exp);
    check(!empty_o && mask_o == exp, req, 32'(mask_o), 32'(exp));
    got = mask_o;
    pop_i = 1'b1;
    @(negedge clk);
    pop_i = 1'b0;
  endtask

  function automatic logic [K*LW-1:0] rand_seeds();
    logic [K*LW-1:0] s;
    for (int j = 0; j < K; j++) s[j*LW +: LW] = $urandom() | 32'h1;
    return s;
  endfunction

  initial begin
    logic [K*LW-1:0] sd1;
    logic [PF-1:0]   w, first1;
    int ones1, ones3, r;
    r = $urandom(32'd20240);
    sd1 = rand_seeds();
    do_reset(sd1, 2'd1);
    check(empty_o == 1'b1, "R1 empty after reset", 32'(empty_o), 32'd1);
    // pop into an empty queue must be ignored
    pop_i = 1'b1; @(negedge clk); pop_i = 1'b0;
    check(empty_o == 1'b1, "R8 empty pop ignored", 32'(empty_o), 32'd1);
    pop_check("R8 R2 first word intact", first1);
    ones1 = $countones(first1);
    for (int i = 0; i < 15; i++) begin
      repeat ($urandom_range(0, 3 * (PF + 1))) @(negedge clk);
      pop_check("R2 R5 R7 R9 random-gap word", w);
      ones1 += $countones(w);
    end
    // idle long enough to fill the queue and stall the generator
    repeat ((PF + 1) * (DEPTH + 4)) @(negedge clk);
    check(empty_o == 1'b0, "R7 queue filled", 32'(empty_o), 32'd0);
    for (int i = 0; i < DEPTH + 4; i++) pop_check("R6 R9 after stall", w);

    do_reset(rand_seeds(), 2'd2);
    check(empty_o == 1'b1, "R1 empty after second reset", 32'(empty_o), 32'd1);
    for (int i = 0; i < 10; i++) pop_check("R4 k=2 word", w);

    do_reset(rand_seeds(), 2'd3);
    ones3 = 0;
    for (int i = 0; i < 16; i++) begin
      pop_check("R4 k=3 word", w);
      ones3 += $countones(w);
    end
    check(ones3 < ones1, "R4 k=3 sparser than k=1", 32'(ones3), 32'(ones1));

    // code 0 acts as k=1; slice 0 zero is replaced by 1
    begin
      logic [K*LW-1:0] sd0;
      sd0 = rand_seeds();
      sd0[0 +: LW] = '0;
      do_reset(sd0, 2'd0);
      for (int i = 0; i < 8; i++) pop_check("R3 R4 zero seed, code 0", w);
    end

    do_reset(sd1, 2'd1);
    pop_check("R1 restart from seeds", w);
    check(w == first1, "R1 same first word", 32'(w), 32'(first1));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule